// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a synchronous host reach an external asynchronous static RAM of the 45 ns class. The host raises a request carrying an address, a read/write flag and write data, and holds it until a one-cycle acknowledge comes back. On a read, the captured word arrives on the same cycle as the acknowledge. On the memory side the controller drives the address, an active-low select, an active-high select, an active-low read (output) enable and an active-low write enable. The data bus is split into an output word, a per-bit drive enable and an input word, ready for a pad ring.

Every memory timing limit is a parameter in picoseconds, as is the clock period. At elaboration each limit becomes a whole number of cycles. A read holds its strobes for a window long enough for both the address-to-data and the enable-to-data limits, and for the minimum cycle time. A write keeps the write enable low long enough for the pulse-width rule, the address-setup rule and the data-setup rule, then ends the write with the rising edge of the write enable. After every read, a release interval passes before the controller accepts another request. This keeps the controller from driving the bus while the memory may still be driving it.

Top module: `sram_timing_ctrl`

## Requirements
- R1: Each timing limit becomes ceil(limit_ps / CLK_PERIOD_PS) cycles, with a minimum of one. At the default 5000 ps clock the windows are: read 9 cycles, release 4, write-enable low 7, post-write hold 2.
- R2: A read request, once accepted, asserts the address, both selects and `mem_rd_en_n`=0 together on the next edge. They stay asserted for exactly the read window. The word on `mem_dq_in` at the end of the window appears on `host_rdata` in the cycle in which `host_ack` is 1.
- R3: The memory counts as selected only when `mem_sel_n`=0 and `mem_sel_hi`=1. Outside an access both selects are inactive (`mem_sel_n`=1, `mem_sel_hi`=0). `mem_wr_en_n` is 0 only while the memory is selected.
- R4: A write holds `mem_wr_en_n` low for exactly the write window, with the data driven throughout. The write ends with `mem_wr_en_n` rising while the selects are still active. Address, data and selects then stay in place for the hold window.
- R5: The data drive enables are set only during a write, and never while `mem_rd_en_n` is 0. They are set only after `mem_rd_en_n` has been 1 for at least the release window. `mem_rd_en_n` is 1 throughout every write.
- R6: The address stays constant for the whole time the memory is selected, and the write data stays constant while it is driven. Changing the host fields after the request has been accepted has no effect.
- R7: `host_ack` is high for exactly one cycle per access. A request is accepted only in the idle state, and not in the cycle in which `host_ack` is high. After a read, the release window passes before the next request is accepted: a write issued right after a read completes 12 cycles after the host raises its request, against 10 from idle.
- R8: After reset, both selects, `mem_rd_en_n` and `mem_wr_en_n` are inactive, no data bit is driven, `host_ack` is 0 and `host_rdata` is 0.
- R9: The memory stays selected for at least the minimum cycle time in every access: 9 cycles for a read (read window) and 9 for a write (write window plus hold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_PS |
| rst_n | input | 1 | Active-low reset, synchronous |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with host_ack on a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | DATA_W | Per-bit drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data returned from the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_rd_en_n | output | 1 | Active-low memory output enable |
| mem_wr_en_n | output | 1 | Active-low write enable |

## Verification
The hardest situation to reach is a write that follows a read at once. Here the controller must let the release window expire after the read enable rises before it turns on its drivers. From the ports this shows up only as a few cycles of extra latency and a gap between two pins. The bench issues a read and then a write back to back, and measures both the completion latency and the number of cycles the read enable has been high at the moment the drive enables rise. A memory model that counts cycles flags early sampling, short pulses and bus overlap. A second hard case is a host that changes its fields in the middle of a write. The bench scrambles the address and data once the selects are active, then reads back both the original and the scrambled address.

// File: rtl/sram_timing_pkg.sv
`timescale 1ns/1ps
package sram_timing_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ACCESS,
      ST_RD_RELEASE,
      ST_WR_PULSE,
      ST_WR_HOLD
   } seq_state_t;

   // ceiling of a time limit against the clock period, at least one cycle
   function automatic int ps_to_cycles(input int limit_ps, input int period_ps);
      int c;
      c = (limit_ps + period_ps - 1) / period_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

   // R1: a running window shortens by exactly one cycle per clock
   assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
   import sram_timing_pkg::*;
#(
   parameter int RD_CYC   = 9,
   parameter int REL_CYC  = 4,
   parameter int WE_CYC   = 7,
   parameter int HOLD_CYC = 2,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_wr,
   input  logic             timer_done,
   output logic             accept,
   output logic             capture,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val,
   output logic             sel_act,
   output logic             rd_act,
   output logic             wr_act,
   output logic             drive_act,
   output logic             ack
);

   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] REL_LD  = CNT_W'(REL_CYC - 1);
   localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);

   seq_state_t state_q;
   logic       sel_q, rd_q, wr_q, drv_q, ack_q;

   assign accept  = (state_q == ST_IDLE) && req && !ack_q;
   assign capture = (state_q == ST_RD_ACCESS) && timer_done;

   always_comb begin
      timer_load = 1'b0;
      timer_val  = '0;
      if (accept) begin
         timer_load = 1'b1;
         timer_val  = req_wr ? WE_LD : RD_LD;
      end else if (state_q == ST_RD_ACCESS && timer_done) begin
         timer_load = 1'b1;
         timer_val  = REL_LD;
      end else if (state_q == ST_WR_PULSE && timer_done) begin
         timer_load = 1'b1;
         timer_val  = HOLD_LD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= 1'b0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
         drv_q   <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  sel_q   <= 1'b1;
                  rd_q    <= !req_wr;
                  wr_q    <= req_wr;
                  drv_q   <= req_wr;
                  state_q <= req_wr ? ST_WR_PULSE : ST_RD_ACCESS;
               end
            end
            ST_RD_ACCESS: begin
               if (timer_done) begin
                  sel_q   <= 1'b0;
                  rd_q    <= 1'b0;
                  ack_q   <= 1'b1;
                  state_q <= ST_RD_RELEASE;
               end
            end
            ST_RD_RELEASE: begin
               if (timer_done) state_q <= ST_IDLE;
            end
            ST_WR_PULSE: begin
               if (timer_done) begin
                  wr_q    <= 1'b0;
                  state_q <= ST_WR_HOLD;
               end
            end
            ST_WR_HOLD: begin
               if (timer_done) begin
                  sel_q   <= 1'b0;
                  drv_q   <= 1'b0;
                  ack_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sel_act   = sel_q;
   assign rd_act    = rd_q;
   assign wr_act    = wr_q;
   assign drive_act = drv_q;
   assign ack       = ack_q;

   // R5: read enable and data drive never overlap
   assert_rd_drive_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_q |-> !drv_q);

endmodule

// File: rtl/sram_io_path.sv
`timescale 1ns/1ps
module sram_io_path #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic              capture,
   input  logic              drive,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] mem_dq_oe,
   output logic [DATA_W-1:0] host_rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (latch) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
         end
         if (capture) rdata_q <= mem_dq_in;
      end
   end

   // one drive enable per pad
   for (genvar b = 0; b < DATA_W; b++) begin : g_pad_oe
      assign mem_dq_oe[b] = drive;
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign host_rdata = rdata_q;

endmodule

// File: rtl/sram_timing_ctrl.sv
`timescale 1ns/1ps
module sram_timing_ctrl
   import sram_timing_pkg::*;
#(
   parameter int ADDR_W            = 16,
   parameter int DATA_W            = 16,
   parameter int CLK_PERIOD_PS     = 5000,
   parameter int T_CYCLE_PS        = 45000,
   parameter int T_ADDR_DATA_PS    = 45000,
   parameter int T_RDEN_DATA_PS    = 22000,
   parameter int T_BUS_RELEASE_PS  = 18000,
   parameter int T_WE_PULSE_PS     = 35000,
   parameter int T_ADDR_TO_WEND_PS = 35000,
   parameter int T_DATA_TO_WEND_PS = 25000,
   parameter int T_WR_HOLD_PS      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_sel_n,
   output logic              mem_sel_hi,
   output logic              mem_rd_en_n,
   output logic              mem_wr_en_n
);

   localparam int CYC_MIN  = ps_to_cycles(T_CYCLE_PS, CLK_PERIOD_PS);
   localparam int RD_CYC   = max_of(CYC_MIN,
                               max_of(ps_to_cycles(T_ADDR_DATA_PS, CLK_PERIOD_PS),
                                      ps_to_cycles(T_RDEN_DATA_PS, CLK_PERIOD_PS)));
   localparam int REL_CYC  = ps_to_cycles(T_BUS_RELEASE_PS, CLK_PERIOD_PS);
   localparam int WE_CYC   = max_of(ps_to_cycles(T_WE_PULSE_PS, CLK_PERIOD_PS),
                               max_of(ps_to_cycles(T_ADDR_TO_WEND_PS, CLK_PERIOD_PS),
                                      ps_to_cycles(T_DATA_TO_WEND_PS, CLK_PERIOD_PS)));
   localparam int HOLD_CYC = max_of(ps_to_cycles(T_WR_HOLD_PS, CLK_PERIOD_PS),
                                    CYC_MIN - WE_CYC);
   localparam int MAX_CYC  = max_of(max_of(RD_CYC, REL_CYC), max_of(WE_CYC, HOLD_CYC));
   localparam int CNT_W    = $clog2(MAX_CYC + 1);
   localparam int RUN_W    = CNT_W + 1;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_timing_ctrl: address and data widths must be positive");
   end
   if (CLK_PERIOD_PS < 1) begin : g_bad_period
      $error("sram_timing_ctrl: clock period must be positive");
   end

   logic             accept, capture, timer_load, timer_done;
   logic [CNT_W-1:0] timer_val;
   logic             sel_act, rd_act, wr_act, drive_act;

   sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (timer_val),
      .done     (timer_done)
   );

   sram_seq_fsm #(
      .RD_CYC   (RD_CYC),
      .REL_CYC  (REL_CYC),
      .WE_CYC   (WE_CYC),
      .HOLD_CYC (HOLD_CYC),
      .CNT_W    (CNT_W)
   ) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (host_req),
      .req_wr     (host_wr),
      .timer_done (timer_done),
      .accept     (accept),
      .capture    (capture),
      .timer_load (timer_load),
      .timer_val  (timer_val),
      .sel_act    (sel_act),
      .rd_act     (rd_act),
      .wr_act     (wr_act),
      .drive_act  (drive_act),
      .ack        (host_ack)
   );

   sram_io_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_io (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch      (accept),
      .capture    (capture),
      .drive      (drive_act),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .host_rdata (host_rdata)
   );

   assign mem_sel_n   = !sel_act;
   assign mem_sel_hi  = sel_act;
   assign mem_rd_en_n = !rd_act;
   assign mem_wr_en_n = !wr_act;

   // ---------------- checker support: run lengths of pin levels
   localparam logic [RUN_W-1:0] REL_RUN = RUN_W'(REL_CYC);
   localparam logic [RUN_W-1:0] WE_RUN  = RUN_W'(WE_CYC);

   logic [RUN_W-1:0] rden_hi_run, wren_lo_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rden_hi_run <= '1;
         wren_lo_run <= '0;
      end else begin
         if (!mem_rd_en_n)          rden_hi_run <= '0;
         else if (rden_hi_run != '1) rden_hi_run <= rden_hi_run + 1'b1;
         if (mem_wr_en_n)            wren_lo_run <= '0;
         else if (wren_lo_run != '1) wren_lo_run <= wren_lo_run + 1'b1;
      end
   end

   // R3: write enable only while both selects are active
   assert_wr_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_en_n |-> (!mem_sel_n && mem_sel_hi));

   // R4: the write ends on the write-enable edge after a full pulse
   assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_en_n) |-> (wren_lo_run >= WE_RUN && !mem_sel_n));

   // R5: drivers only after the memory has released the bus
   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|mem_dq_oe) |-> (mem_rd_en_n && rden_hi_run >= REL_RUN));

   // R6: address fixed while selected
   assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

   // R6: write data fixed while driven
   assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|mem_dq_oe) && $past(|mem_dq_oe)) |-> $stable(mem_dq_out));

   // R7: acknowledge is a single-cycle pulse
   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

endmodule

// File: tb/test_sram_timing_ctrl.sv
`timescale 1ns/1ps
module test_sram_timing_ctrl;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int PERIOD_PS = 5000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_req = 1'b0;
   logic          host_wr = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          host_ack;
   logic [DW-1:0] host_rdata;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out, mem_dq_oe, mem_dq_in;
   logic          mem_sel_n, mem_sel_hi, mem_rd_en_n, mem_wr_en_n;

   always #2.5 clk = ~clk;

   sram_timing_ctrl i_sram_timing_ctrl (
      .clk (clk), .rst_n (rst_n),
      .host_req (host_req), .host_wr (host_wr), .host_addr (host_addr),
      .host_wdata (host_wdata), .host_ack (host_ack), .host_rdata (host_rdata),
      .mem_addr (mem_addr), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
      .mem_dq_in (mem_dq_in), .mem_sel_n (mem_sel_n), .mem_sel_hi (mem_sel_hi),
      .mem_rd_en_n (mem_rd_en_n), .mem_wr_en_n (mem_wr_en_n)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- cycle-counting memory model
   logic [DW-1:0] mdl_mem [64];
   logic [DW-1:0] sb      [64];
   int  rd_run = 0, we_run = 0, sel_run = 0, adr_run = 0, dat_run = 0, oehi_run = 1000;
   int  violations = 0;
   logic          prev_we_n = 1'b1, prev_sel = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dout = '0;
   wire sel = !mem_sel_n && mem_sel_hi;

   assign mem_dq_in = (sel && !mem_rd_en_n && (rd_run + 1) * PERIOD_PS >= 45000 &&
                       (rd_run + 1) * PERIOD_PS >= 22000) ? mdl_mem[mem_addr[5:0]] : 16'hDEAD;

   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_wr_en_n && !prev_we_n) begin
            if (we_run * PERIOD_PS < 35000) begin violations++; $display("model: short write pulse"); end
            if (adr_run * PERIOD_PS < 35000) begin violations++; $display("model: address setup"); end
            if (dat_run * PERIOD_PS < 25000) begin violations++; $display("model: data setup"); end
            if (!sel || !mem_dq_oe[0]) begin violations++; $display("model: write ended by wrong edge"); end
            mdl_mem[mem_addr[5:0]] = mem_dq_out;
         end
         if (prev_sel && !sel && sel_run * PERIOD_PS < 45000) begin
            violations++; $display("model: cycle time");
         end
         if (mem_dq_oe[0] && (!mem_rd_en_n || oehi_run * PERIOD_PS < 18000)) begin
            violations++; $display("model: bus overlap");
         end
         we_run   = !mem_wr_en_n ? we_run + 1 : 0;
         rd_run   = (sel && !mem_rd_en_n) ? rd_run + 1 : 0;
         sel_run  = sel ? sel_run + 1 : 0;
         adr_run  = sel ? ((mem_addr == prev_addr) ? adr_run + 1 : 1) : 0;
         dat_run  = mem_dq_oe[0] ? ((mem_dq_out == prev_dout) ? dat_run + 1 : 1) : 0;
         oehi_run = mem_rd_en_n ? oehi_run + 1 : 0;
         prev_we_n = mem_wr_en_n;
         prev_sel  = sel;
         prev_addr = mem_addr;
         prev_dout = mem_dq_out;
      end
   end

   // ---------------- pin monitor
   int  rden_hi_cnt = 1000;
   int  drive_gap   = 1000;
   int  bad_overlap = 0;
   logic drv_prev   = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe[0] && !drv_prev) drive_gap = rden_hi_cnt;
         if ((|mem_dq_oe) && !mem_rd_en_n) bad_overlap++;
         drv_prev    = mem_dq_oe[0];
         rden_hi_cnt = mem_rd_en_n ? rden_hi_cnt + 1 : 0;
      end
   end

   // ---------------- one host access, with pin counts
   task automatic do_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit scramble, output logic [DW-1:0] rd,
                            output int we_lo, output int oe_lo, output int sel_lo,
                            output int lat);
      @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      we_lo = 0; oe_lo = 0; sel_lo = 0; lat = 0; rd = '0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         lat++;
         if (!mem_wr_en_n) we_lo++;
         if (!mem_rd_en_n) oe_lo++;
         if (sel) sel_lo++;
         if (scramble && sel) begin
            host_addr  = ~a & 16'h003F;
            host_wdata = ~d;
         end
         if (host_ack) begin
            rd = host_rdata;
            break;
         end
      end
      host_req = 1'b0;
      @(negedge clk);
      check(!host_ack && mem_sel_n && !mem_sel_hi, "R7", "ack single, no re-accept",
            {30'd0, host_ack, sel}, 32'd0);
   endtask

   task automatic wr_word(input logic [5:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] rd;
      int we_lo, oe_lo, sel_lo, lat;
      do_access(1'b1, {10'd0, a}, d, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      sb[a] = d;
      check(we_lo == 7, "R4", "write enable low cycles", we_lo, 7);
      check(oe_lo == 0, "R5", "read enable during write", oe_lo, 0);
      check(sel_lo == 9, "R9", "write select cycles", sel_lo, 9);
   endtask

   task automatic rd_word(input logic [5:0] a);
      logic [DW-1:0] rd;
      int we_lo, oe_lo, sel_lo, lat;
      do_access(1'b0, {10'd0, a}, '0, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      check(rd == sb[a], "R2", "read data", rd, sb[a]);
      check(oe_lo == 9 && we_lo == 0, "R2", "read window cycles", oe_lo, 9);
      check(sel_lo == 9, "R9", "read select cycles", sel_lo, 9);
   endtask

   // ---------------- scenarios
   task automatic t_reset();
      check(mem_sel_n && !mem_sel_hi && mem_rd_en_n && mem_wr_en_n, "R8", "strobes idle",
            {28'd0, mem_sel_n, mem_sel_hi, mem_rd_en_n, mem_wr_en_n}, 32'hB);
      check(mem_dq_oe == '0 && !host_ack && host_rdata == '0, "R8", "drive/ack/rdata",
            {mem_dq_oe, host_rdata}, 32'd0);
      check(mem_sel_n && !mem_sel_hi, "R3", "deselected in idle",
            {30'd0, mem_sel_n, mem_sel_hi}, 32'h2);
   endtask

   task automatic t_single();
      logic [DW-1:0] rd;
      int we_lo, oe_lo, sel_lo, lat;
      do_access(1'b1, 16'd5, 16'hA5A5, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      sb[5] = 16'hA5A5;
      check(we_lo == 7, "R1", "derived write window", we_lo, 7);
      check(lat == 10, "R7", "write latency from idle", lat, 10);
      do_access(1'b0, 16'd5, 16'h0, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      check(oe_lo == 9, "R1", "derived read window", oe_lo, 9);
      check(rd == 16'hA5A5, "R2", "read back single", rd, 16'hA5A5);
   endtask

   task automatic t_patterns();
      wr_word(6'd0, 16'h0000);
      wr_word(6'd63, 16'hFFFF);
      wr_word(6'd10, 16'h5A5A);
      wr_word(6'd33, 16'h8001);
      rd_word(6'd63);
      rd_word(6'd0);
      rd_word(6'd33);
      rd_word(6'd10);
      rd_word(6'd20);
   endtask

   task automatic t_scramble();
      logic [DW-1:0] rd;
      int we_lo, oe_lo, sel_lo, lat;
      do_access(1'b1, 16'd12, 16'h3C3C, 1'b1, rd, we_lo, oe_lo, sel_lo, lat);
      sb[12] = 16'h3C3C;
      do_access(1'b0, 16'd12, 16'h0, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      check(rd == 16'h3C3C, "R6", "original address kept data", rd, 16'h3C3C);
      do_access(1'b0, 16'd51, 16'h0, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      check(rd == sb[51], "R6", "scrambled address untouched", rd, sb[51]);
   endtask

   task automatic t_turnaround();
      logic [DW-1:0] rd;
      int we_lo, oe_lo, sel_lo, lat;
      do_access(1'b0, 16'd33, 16'h0, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      check(rd == sb[33], "R2", "read before turnaround", rd, sb[33]);
      do_access(1'b1, 16'd34, 16'h7E81, 1'b0, rd, we_lo, oe_lo, sel_lo, lat);
      sb[34] = 16'h7E81;
      check(lat == 12, "R7", "write latency after read", lat, 12);
      check(drive_gap >= 4, "R5", "read enable high before drive", drive_gap, 4);
      check(bad_overlap == 0, "R5", "drive while read enabled", bad_overlap, 0);
      rd_word(6'd34);
   endtask

   // ---------------- watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // ---------------- main
   initial begin
      for (int i = 0; i < 64; i++) begin
         mdl_mem[i] = 16'h1000 + 16'(i);
         sb[i]      = 16'h1000 + 16'(i);
      end
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_patterns();
      t_scramble();
      t_turnaround();
      repeat (3) @(negedge clk);
      check(violations == 0, "R4", "memory model timing violations", violations, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule